// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an asynchronous EDO DRAM and owns the row strobe, column strobe, write enable and row address lines whenever no read/write engine is using them. When reset is released it waits out the power-up pause and then runs eight initialization cycles. After that it keeps the array refreshed on a fixed interval. It also takes the device into and out of self-refresh, adding the extra refresh cycles that each refresh policy needs around that state.

Two static inputs choose how refresh is done. The first picks the cycle type: row-address-only cycles, with the row taken from an internal counter, or column-before-row cycles, where the device counts rows itself. The second picks the policy: one cycle per interval (distributed), or a back-to-back set of all rows once every row-count intervals (burst). A separate access engine asks for the bus with a request line and holds it while the grant is high. A due refresh is signalled back to the engine, and no new grant is given until that refresh has been done.

All timing values are given in nanoseconds and converted to clock counts at elaboration.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, for the pause count (PAUSE_NS rounded up to whole clocks), ras_n, cas_n and we_n stay high, acc_gnt and init_done stay low and busy is high, even if acc_req is high.
- R2: With cbr_mode=0 the pause is followed by exactly INIT_CYC row-only cycles on rows 0 to INIT_CYC-1. init_done then rises, with row_addr equal to INIT_CYC.
- R3: With cbr_mode=1 the pause is followed by exactly INIT_CYC column-before-row cycles, and init_done rises after the last one.
- R4: A column-before-row cycle holds cas_n low with ras_n high for the setup count. It then holds both low for the strobe-low count, raises ras_n one clock before cas_n, and keeps we_n high throughout.
- R5: A row-only cycle holds ras_n low for the strobe-low count with cas_n high. row_addr does not change while ras_n is low, and it advances by one as ras_n rises, wrapping from ROWS-1 to 0.
- R6: Every refresh cycle ends with ras_n and cas_n both high for at least the precharge count before ras_n falls again.
- R7: After init, rf_want rises once every refresh interval when burst_mode=0, and once every ROWS intervals when burst_mode=1. It clears when the refresh it asked for is complete. That refresh is one cycle (distributed) or ROWS back-to-back cycles (burst).
- R8: acc_gnt rises only when the block is idle, init_done is high and no refresh is pending, and it falls the clock after acc_req drops. While acc_gnt is high, ras_n and cas_n stay high, and a pending refresh waits for acc_req to drop.
- R9: On sr_req, a full set of ROWS refresh cycles is run first, unless the mode is distributed column-before-row. The block then starts a column-before-row cycle and holds both strobes low, and sr_ack rises once they have been low for the self-refresh count.
- R10: When sr_req drops with sr_ack high, ras_n rises and then cas_n. The block then runs one column-before-row cycle (distributed column-before-row) or ROWS cycles (any other setting), and sr_ack falls after the last one.
- R11: busy is high whenever the block is pausing, running a cycle or holding self-refresh, and low when it is idle or has granted the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbr_mode | input | 1 | 1: column-before-row refresh, 0: row-only refresh |
| burst_mode | input | 1 | 1: burst refresh policy, 0: distributed |
| sr_req | input | 1 | Self-refresh request, held high for the stay |
| acc_req | input | 1 | Access engine asks for the bus |
| acc_gnt | output | 1 | Bus granted to the access engine |
| rf_want | output | 1 | A refresh is due; engine should release the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row address for row-only refresh |
| sr_ack | output | 1 | Device is in self-refresh or finishing its exit refresh |
| init_done | output | 1 | Initialization complete |
| busy | output | 1 | Sequencer occupies the DRAM lines |

## Verification
The bench runs all four combinations of cycle type and policy, each from a fresh reset. The corner cases are a grant asked for during the pause, a refresh falling due while the engine holds the bus, row counter wrap during a pre-entry burst, and the self-refresh exit with its policy-dependent refresh count. A design that granted early would drive acc_gnt during the pause. One that pre-empted the engine would pulse the strobes under an active grant. One with the wrong exit rule would drop sr_ack after one cycle where a full set is owed, or after a full set where one is enough. Precharge gaps and the order of the strobe edges are compared on every clock, so a strobe released in the wrong order, or a row that moves under a low ras_n, shows up at the exact cycle.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_NS    = 20,
  parameter int PAUSE_NS  = 100000,
  parameter int T_RAS_NS  = 50,
  parameter int T_RP_NS   = 30,
  parameter int T_CSR_NS  = 10,
  parameter int T_SR_NS   = 100000,
  parameter int REFI_NS   = 15600,
  parameter int ROWS      = 4096,
  parameter int INIT_CYC  = 8,
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbr_mode,
  input  logic             burst_mode,
  input  logic             sr_req,
  input  logic             acc_req,
  output logic             acc_gnt,
  output logic             rf_want,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             sr_ack,
  output logic             init_done,
  output logic             busy
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PAUSE_C = to_cyc(PAUSE_NS);
  localparam int RAS_C   = to_cyc(T_RAS_NS);
  localparam int RP_C    = to_cyc(T_RP_NS);
  localparam int CSR_C   = to_cyc(T_CSR_NS);
  localparam int SR_C    = to_cyc(T_SR_NS);
  localparam int REFI_C  = to_cyc(REFI_NS);
  localparam int CW      = $clog2(max2(max2(PAUSE_C, SR_C), max2(max2(RAS_C, RP_C), CSR_C)) + 1);
  localparam int LW      = $clog2(max2(ROWS, INIT_CYC) + 1);
  localparam int TW      = $clog2(REFI_C + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_GRANT, S_CSR, S_RASL, S_RELR, S_PRE, S_HOLD} st_t;
  typedef enum logic [1:0] {Q_INIT, Q_REF, Q_PRESR, Q_POST} seq_t;

  st_t              st;
  seq_t             seq;
  logic [CW-1:0]    cnt;
  logic [LW-1:0]    left;
  logic             cyc_cbr, sr_cyc, pend;
  logic [ROW_W-1:0] row;
  logic [TW-1:0]    refi;
  logic [ROW_W-1:0] tick_n;

  wire cnt_z    = (cnt == '0);
  wire last     = (st == S_PRE) && cnt_z && !sr_cyc && (left <= LW'(1));
  wire pend_clr = last && (seq == Q_REF || seq == Q_POST);
  wire no_pre   = cbr_mode && !burst_mode;
  wire [LW-1:0] full_n = LW'(ROWS);
  wire [LW-1:0] post_n = no_pre ? LW'(1) : LW'(ROWS);
  st_t start_st;
  assign start_st = cbr_mode ? S_CSR : S_RASL;
  wire [CW-1:0] start_cnt = cbr_mode ? CW'(CSR_C - 1) : CW'(RAS_C - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      seq       <= Q_INIT;
      cnt       <= CW'(PAUSE_C - 1);
      left      <= LW'(INIT_CYC);
      cyc_cbr   <= 1'b0;
      sr_cyc    <= 1'b0;
      row       <= '0;
      sr_ack    <= 1'b0;
      init_done <= 1'b0;
    end else begin
      case (st)
        S_PAUSE: begin
          if (cnt_z) begin
            st      <= start_st;
            cnt     <= start_cnt;
            cyc_cbr <= cbr_mode;
          end else cnt <= cnt - CW'(1);
        end
        S_IDLE: begin
          if (pend) begin
            seq     <= Q_REF;
            left    <= burst_mode ? full_n : LW'(1);
            st      <= start_st;
            cnt     <= start_cnt;
            cyc_cbr <= cbr_mode;
          end else if (sr_req) begin
            if (no_pre) begin
              st      <= S_CSR;
              cnt     <= CW'(CSR_C - 1);
              cyc_cbr <= 1'b1;
              sr_cyc  <= 1'b1;
            end else begin
              seq     <= Q_PRESR;
              left    <= full_n;
              st      <= start_st;
              cnt     <= start_cnt;
              cyc_cbr <= cbr_mode;
            end
          end else if (acc_req) st <= S_GRANT;
        end
        S_GRANT: if (!acc_req) st <= S_IDLE;
        S_CSR: begin
          if (cnt_z) begin
            st  <= sr_cyc ? S_HOLD : S_RASL;
            cnt <= sr_cyc ? CW'(SR_C - 1) : CW'(RAS_C - 1);
          end else cnt <= cnt - CW'(1);
        end
        S_RASL: begin
          if (cnt_z) begin
            if (cyc_cbr) st <= S_RELR;
            else begin
              st  <= S_PRE;
              cnt <= CW'(RP_C - 1);
              row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + ROW_W'(1);
            end
          end else cnt <= cnt - CW'(1);
        end
        S_RELR: begin
          st  <= S_PRE;
          cnt <= CW'(RP_C - 1);
        end
        S_HOLD: begin
          if (!cnt_z) cnt <= cnt - CW'(1);
          else if (!sr_ack) sr_ack <= 1'b1;
          else if (!sr_req) st <= S_RELR;
        end
        S_PRE: begin
          if (!cnt_z) cnt <= cnt - CW'(1);
          else if (sr_cyc) begin
            sr_cyc  <= 1'b0;
            seq     <= Q_POST;
            left    <= post_n;
            st      <= start_st;
            cnt     <= start_cnt;
            cyc_cbr <= cbr_mode;
          end else if (left > LW'(1)) begin
            left    <= left - LW'(1);
            st      <= start_st;
            cnt     <= start_cnt;
            cyc_cbr <= cbr_mode;
          end else begin
            case (seq)
              Q_INIT: begin
                init_done <= 1'b1;
                st        <= S_IDLE;
              end
              Q_REF: st <= S_IDLE;
              Q_PRESR: begin
                st      <= S_CSR;
                cnt     <= CW'(CSR_C - 1);
                cyc_cbr <= 1'b1;
                sr_cyc  <= 1'b1;
              end
              default: begin
                sr_ack <= 1'b0;
                st     <= S_IDLE;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire tick = init_done && (refi == TW'(REFI_C - 1));
  wire pset = tick && (!burst_mode || tick_n == ROW_W'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refi   <= '0;
      tick_n <= '0;
      pend   <= 1'b0;
    end else begin
      if (init_done) refi <= tick ? '0 : refi + TW'(1);
      if (tick) tick_n <= (tick_n == ROW_W'(ROWS - 1)) ? '0 : tick_n + ROW_W'(1);
      pend <= pset | (pend & ~pend_clr);
    end
  end

  assign ras_n    = !(st == S_RASL || st == S_HOLD);
  assign cas_n    = !(st == S_CSR || st == S_HOLD || st == S_RELR || (st == S_RASL && cyc_cbr));
  assign we_n     = 1'b1;
  assign row_addr = row;
  assign acc_gnt  = (st == S_GRANT);
  assign rf_want  = pend;
  assign busy     = !(st == S_IDLE || st == S_GRANT);

  AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |-> $stable(row_addr)); // R5
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R4
  AST_RAS_RISES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $past(ras_n)); // R4
  AST_GNT_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> init_done); // R8
  AST_GNT_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (ras_n && cas_n)); // R8
  AST_ACK_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ack) |-> !busy); // R10

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int ROWS = 16, RAS_C = 3, RP_C = 2, CSR_C = 1, SR_C = 10;
  localparam int REFI_C = 100, PAUSE_C = 100, INIT_N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cbr = 1'b0, burst = 1'b0, sr_req = 1'b0, acc_req = 1'b0;
  logic acc_gnt, rf_want, ras_n, cas_n, we_n, sr_ack, init_done, busy;
  logic [3:0] row_addr;

  dram_refresh_seq #(.CLK_NS(20), .PAUSE_NS(2000), .T_RAS_NS(60), .T_RP_NS(40),
    .T_CSR_NS(20), .T_SR_NS(200), .REFI_NS(2000), .ROWS(ROWS), .INIT_CYC(INIT_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cbr_mode(cbr), .burst_mode(burst), .sr_req(sr_req),
    .acc_req(acc_req), .acc_gnt(acc_gnt), .rf_want(rf_want), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(row_addr), .sr_ack(sr_ack), .init_done(init_done), .busy(busy));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_en = 0, stim_done = 0;
  bit e_ras, e_cas, e_gnt, e_ack, e_done, e_busy, m_pend, m_set, m_pold;
  int e_row, m_refi, m_tickn;

  task automatic check(string req, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    m_pold = m_pend;
    m_set = 0;
    if (e_done) begin
      if (m_refi == REFI_C - 1) begin
        m_refi = 0;
        if (!burst || m_tickn == ROWS - 1) m_set = 1;
        m_tickn = (m_tickn + 1) % ROWS;
      end else m_refi++;
    end
    m_pend = m_pend | m_set;
  endtask

  task automatic seg(int n, bit r, bit c);
    e_ras = r; e_cas = c;
    repeat (n) step();
  endtask

  task automatic mode_cyc();
    if (cbr) begin
      seg(CSR_C, 1, 0); seg(RAS_C, 0, 0); seg(1, 1, 0); seg(RP_C, 1, 1);
    end else begin
      seg(RAS_C, 0, 1); e_row = (e_row + 1) % ROWS; seg(RP_C, 1, 1);
    end
  endtask

  task automatic model_reset();
    e_ras = 1; e_cas = 1; e_gnt = 0; e_ack = 0; e_done = 0; e_busy = 1;
    m_pend = 0; m_set = 0; m_refi = 0; m_tickn = 0; e_row = 0;
  endtask

  task automatic model();
    int post;
    post = (cbr && !burst) ? 1 : ROWS;
    @(posedge rst_n);
    repeat (PAUSE_C) step();
    repeat (INIT_N) mode_cyc();
    e_done = 1; e_busy = 0;
    forever begin
      step();
      if (stim_done) break;
      if (m_pold) begin
        e_busy = 1;
        repeat (burst ? ROWS : 1) mode_cyc();
        m_pend = m_set; e_busy = 0;
      end else if (sr_req) begin
        e_busy = 1;
        if (!(cbr && !burst)) repeat (ROWS) mode_cyc();
        seg(CSR_C, 1, 0);
        seg(SR_C, 0, 0);
        e_ack = 1;
        do step(); while (sr_req);
        seg(1, 1, 0); seg(RP_C, 1, 1);
        repeat (post) mode_cyc();
        e_ack = 0; m_pend = m_set; e_busy = 0;
      end else if (acc_req) begin
        e_gnt = 1;
        do step(); while (acc_req);
        e_gnt = 0;
      end
    end
    cmp_en = 0;
  endtask

  bit p_ras, p_done, p_ack;
  int hi_run, f_init, f_sr;
  always @(negedge clk) begin
    if (cmp_en) begin
      check(cbr ? "R4" : "R5", "ras_n", ras_n, e_ras);
      check(cbr ? "R4" : "R5", "cas_n", cas_n, e_cas);
      check("R4", "we_n", we_n, 1);
      check("R5", "row_addr", row_addr, e_row);
      check("R8", "acc_gnt", acc_gnt, e_gnt);
      check("R7", "rf_want", rf_want, m_pend);
      check("R9", "sr_ack", sr_ack, e_ack);
      check("R2", "init_done", init_done, e_done);
      check("R11", "busy", busy, e_busy);
    end
    if (!rst_n) begin
      hi_run = 0; f_init = 0; f_sr = 0; p_ras = 1; p_done = 0; p_ack = 0;
    end else begin
      if (p_ras && !ras_n) begin
        if (hi_run < RP_C) check("R6", "precharge clocks", hi_run, RP_C);
        if (!init_done) f_init++;
        if (sr_ack) f_sr++;
      end
      hi_run = ras_n ? hi_run + 1 : 0;
      if (init_done && !p_done) check(cbr ? "R3" : "R2", "init cycle count", f_init, INIT_N);
      if (p_ack && !sr_ack) begin
        check("R10", "exit refresh count", f_sr, (cbr && !burst) ? 1 : ROWS);
        f_sr = 0;
      end
      p_ras = ras_n; p_done = init_done; p_ack = sr_ack;
    end
  end

  task automatic stim();
    @(negedge clk);
    rst_n = 1; acc_req = 1;
    repeat (PAUSE_C / 2) @(negedge clk);
    check("R1", "pause quiet", {ras_n, cas_n, we_n, acc_gnt, init_done, busy}, 6'b111001);
    while (!init_done) @(negedge clk);
    check(cbr ? "R3" : "R2", "row after init", row_addr, cbr ? 0 : INIT_N);
    repeat (250) @(negedge clk);
    acc_req = 0;
    repeat (200) @(negedge clk);
    if (burst) repeat (1700) @(negedge clk);
    acc_req = 1;
    repeat (30) @(negedge clk);
    acc_req = 0;
    repeat (20) @(negedge clk);
    sr_req = 1;
    while (!sr_ack) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R9", "strobes held in self-refresh", {ras_n, cas_n}, 0);
    sr_req = 0;
    while (sr_ack) @(negedge clk);
    repeat (40) @(negedge clk);
    stim_done = 1;
  endtask

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      cmp_en = 0; rst_n = 0; sr_req = 0; acc_req = 0; stim_done = 0;
      cbr = cfg[1]; burst = cfg[0];
      model_reset();
      repeat (3) @(negedge clk);
      cmp_en = 1;
      fork
        model();
        stim();
      join
      @(negedge clk);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule